// File: doc/BRIEF.md
# Serial Two-Digit BCD Pattern Detector

This block watches a one-bit serial stream and flags every place where the last eight bits received spell a fixed two-digit decimal number in BCD. One bit enters on each rising clock edge. The tens digit arrives first, and each digit arrives most significant bit first. The number to watch for is fixed when the block is built. A single decimal selector digit, given as a parameter, picks it from a small table. A selector outside 0 to 9 stops elaboration with an error.

The machine is a Moore machine with one state for each count of pattern bits matched so far, from zero to eight. The flag comes from the state alone. On a mismatch the machine falls back to the longest tail of the received bits that is also a head of the pattern. Because of this, occurrences that share bits are all reported. A typical use is as a tiny framing or keyword spotter behind a serial receiver.

Top module: `bcd_seq_detect`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after any rising edge that samples `rst` high, `match_o` is 0 and no pattern bits count as matched.
- R2: Bits are taken only at rising edges: the tens digit first, then the ones digit, each MSB first. `match_o` is 1 in the cycle right after the edge that sampled the eighth bit of an occurrence, and not before.
- R3: The selector sets the pattern: 0 and 5 give 85 (10000101), 1 and 6 give 97 (10010111), 2 and 7 give 42 (01000010), 3 and 8 give 53 (01010011), 4 and 9 give 28 (00101000).
- R4: Overlapping occurrences are each reported. A stream made of a pattern followed by the bits that extend its longest self-overlap to a second full copy raises `match_o` twice.
- R5: `match_o` is 1 exactly when the last eight bits sampled since reset equal the pattern, and 0 in every other cycle, including when fewer than eight bits have been sampled.
- R6: Moore output: changes on `data_i` between clock edges never change `match_o`.
- R7: For every pattern in the table, `match_o` never stays high for two consecutive cycles.
- R8: A partial match in progress when reset is applied is discarded. The seven leading bits of a pattern, then a reset, then the final bit give no match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; data sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 1 | Serial data bit |
| match_o | output | 1 | High for one cycle after a full pattern is seen |

## Verification
Two things can happen in the same cycle: finishing one occurrence and starting, or already being partway through, the next. The edge that completes a match must also pick the right fallback state, so that an overlapping second copy is still counted. The bench provokes this by sending each pattern followed by the bits that complete its self-overlap. It also sends long random streams to all ten selector variants at once. Each cycle it compares every output with a behavioural model that keeps the last eight bits, and it counts the pulses in the overlap streams.

// File: rtl/bcd_seq_pkg.sv
package bcd_seq_pkg;

    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = 2;
    localparam int PAT_W      = DIGIT_W * NUM_DIGITS;
    localparam int CNT_W      = $clog2(PAT_W + 1);
    localparam int NUM_SEL    = 10;
    localparam int TBL_DEPTH  = 2 ** CNT_W;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [PAT_W-1:0] pattern_t;

    typedef struct packed {
        logic [DIGIT_W-1:0] tens;
        logic [DIGIT_W-1:0] ones;
    } bcd_pair_t;

    // Selector digit to target number; digits d and d+5 share a target.
    function automatic bcd_pair_t pair_for_sel(int sel);
        bcd_pair_t p;
        case (sel % 5)
            0:       begin p.tens = 4'd8; p.ones = 4'd5; end
            1:       begin p.tens = 4'd9; p.ones = 4'd7; end
            2:       begin p.tens = 4'd4; p.ones = 4'd2; end
            3:       begin p.tens = 4'd5; p.ones = 4'd3; end
            default: begin p.tens = 4'd2; p.ones = 4'd8; end
        endcase
        return p;
    endfunction

    // Matched-count after seeing bit b with k bits already matched:
    // longest tail of (first k pattern bits, b) that is a head of the pattern.
    // Sequence position i corresponds to pattern bit PAT_W-1-i.
    function automatic int advance(pattern_t pat, int k, logic b);
        logic [PAT_W:0] seen;
        int             best;
        logic           ok;
        seen = '0;
        best = 0;
        for (int i = 0; i <= PAT_W; i++) begin
            if (i < k)       seen[i] = pat[PAT_W-1-i];
            else if (i == k) seen[i] = b;
        end
        for (int j = 1; j <= PAT_W; j++) begin
            if (j <= k + 1) begin
                ok = 1'b1;
                for (int t = 0; t < j; t++) begin
                    if (seen[k+1-j+t] != pat[PAT_W-1-t]) ok = 1'b0;
                end
                if (ok) best = j;
            end
        end
        return best;
    endfunction

endpackage

// File: rtl/bcd_seq_next.sv
module bcd_seq_next
    import bcd_seq_pkg::*;
#(
    parameter pattern_t PATTERN = 8'b1000_0101
) (
    input  count_t cur_i,
    input  logic   bit_i,
    output count_t nxt_o
);

    count_t on_zero [TBL_DEPTH];
    count_t on_one  [TBL_DEPTH];

    // One row per matched-count; rows beyond a full match are unreachable.
    for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_row
        if (g <= PAT_W) begin : g_live
            localparam count_t NXT0 = count_t'(advance(PATTERN, g, 1'b0));
            localparam count_t NXT1 = count_t'(advance(PATTERN, g, 1'b1));
            assign on_zero[g] = NXT0;
            assign on_one[g]  = NXT1;
        end else begin : g_dead
            assign on_zero[g] = '0;
            assign on_one[g]  = '0;
        end
    end

    always_comb begin
        nxt_o = bit_i ? on_one[cur_i] : on_zero[cur_i];
    end

endmodule

// File: rtl/bcd_seq_state.sv
module bcd_seq_state
    import bcd_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  count_t nxt_i,
    output count_t cur_o,
    output logic   full_o
);

    count_t state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= nxt_i;
    end

    assign cur_o  = state_q;
    assign full_o = (state_q == count_t'(PAT_W));

    // Matched count can grow by at most one bit per edge.
    assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (int'(state_q) <= int'($past(state_q)) + 1));

    // Reset leaves nothing matched.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == '0 && !full_o));

endmodule

// File: rtl/bcd_seq_detect.sv
module bcd_seq_detect
    import bcd_seq_pkg::*;
#(
    parameter int DIGIT_SEL = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic data_i,
    output logic match_o
);

    if (DIGIT_SEL < 0 || DIGIT_SEL >= NUM_SEL) begin : g_bad_sel
        $error("bcd_seq_detect: DIGIT_SEL must lie in 0..9");
    end

    localparam pattern_t PATTERN = pattern_t'(pair_for_sel(DIGIT_SEL));

    count_t cur_cnt;
    count_t nxt_cnt;
    logic   full;

    bcd_seq_next #(.PATTERN(PATTERN)) u_next (
        .cur_i (cur_cnt),
        .bit_i (data_i),
        .nxt_o (nxt_cnt)
    );

    bcd_seq_state u_state (
        .clk    (clk),
        .rst    (rst),
        .nxt_i  (nxt_cnt),
        .cur_o  (cur_cnt),
        .full_o (full)
    );

    assign match_o = full;

    // Observation window for the checks below: raw last PAT_W bits.
    pattern_t hist_q;
    count_t   fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            fill_q <= '0;
        end else begin
            hist_q <= {hist_q[PAT_W-2:0], data_i};
            if (fill_q != count_t'(PAT_W)) fill_q <= fill_q + 1'b1;
        end
    end

    assert_window_hit_R2: assert property (@(posedge clk) disable iff (rst)
        (fill_q == count_t'(PAT_W) && hist_q == PATTERN) |-> match_o);

    assert_no_false_hit_R5: assert property (@(posedge clk) disable iff (rst)
        match_o |-> (fill_q == count_t'(PAT_W) && hist_q == PATTERN));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        match_o |=> !match_o);

endmodule

// File: tb/bcd_seq_detect_tb.sv
`timescale 1ns/1ps
module bcd_seq_detect_tb_top;

    localparam int NSEL = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic [NSEL-1:0] match_w;

    always #2 clk = ~clk;  // 250 MHz

    for (genvar gi = 0; gi < NSEL; gi++) begin : g_dut
        bcd_seq_detect #(.DIGIT_SEL(gi)) dut_i (
            .clk     (clk),
            .rst     (rst),
            .data_i  (din),
            .match_o (match_w[gi])
        );
    end

    int n_run  = 0;
    int n_fail = 0;

    // Targets from R3, written as decimal digits and packed as BCD.
    function automatic logic [7:0] tb_pat(int sel);
        logic [3:0] t, o;
        case (sel % 5)
            0: begin t = 4'd8; o = 4'd5; end
            1: begin t = 4'd9; o = 4'd7; end
            2: begin t = 4'd4; o = 4'd2; end
            3: begin t = 4'd5; o = 4'd3; end
            default: begin t = 4'd2; o = 4'd8; end
        endcase
        return {t, o};
    endfunction

    // Behavioural reference: last eight bits and how many were seen.
    logic [7:0] ref_hist = '0;
    int         ref_cnt  = 0;
    always @(posedge clk) begin
        if (rst) begin
            ref_hist <= '0;
            ref_cnt  <= 0;
        end else begin
            ref_hist <= {ref_hist[6:0], din};
            if (ref_cnt < 8) ref_cnt <= ref_cnt + 1;
        end
    end

    logic [NSEL-1:0] prev_match = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: compare every variant with the model.
    task automatic compare_all();
        for (int s = 0; s < NSEL; s++) begin
            logic exp_m;
            exp_m = (ref_cnt >= 8) && (ref_hist == tb_pat(s));
            check(match_w[s] === exp_m, "R2/R3/R5 stream", $sformatf("sel %0d", s),
                  int'(match_w[s]), int'(exp_m));
            if (prev_match[s])
                check(match_w[s] === 1'b0, "R7 pulse width",
                      $sformatf("sel %0d", s), int'(match_w[s]), 0);
        end
        prev_match = match_w;
    endtask

    // Positioned at a falling edge; wiggle data mid-cycle (R6), then settle.
    task automatic send(input logic b);
        logic [NSEL-1:0] snap;
        din = b;
        #0.5;
        snap = match_w;
        din = ~b;
        #0.5;
        check(match_w === snap, "R6 moore", "mid-cycle data change",
              int'(match_w), int'(snap));
        din = b;
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        din = 1'b0;
        repeat (n) @(negedge clk);
        check(match_w === '0, "R1 reset", "outputs during reset", int'(match_w), 0);
        compare_all();
        rst = 1'b0;
    endtask

    bit finished = 1'b0;

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog expired: got 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] p;
        int hits;
        int border;
        @(negedge clk);
        do_reset(3);

        // R2, R3: each target in order, no early flag, flag after bit eight.
        for (int s = 0; s < 5; s++) begin
            p = tb_pat(s);
            do_reset(1);
            for (int i = 7; i >= 0; i--) begin
                send(p[i]);
                if (i > 0)
                    check(match_w[s] === 1'b0, "R2 early", $sformatf("sel %0d bit %0d", s, i),
                          int'(match_w[s]), 0);
            end
            check(match_w[s] === 1'b1, "R3 target", $sformatf("sel %0d", s), int'(match_w[s]), 1);
            check(match_w[s+5] === 1'b1, "R3 target", $sformatf("sel %0d", s + 5),
                  int'(match_w[s+5]), 1);
        end

        // R4: pattern followed by its self-overlap completion gives two flags.
        for (int s = 0; s < 5; s++) begin
            p = tb_pat(s);
            border = 0;
            for (int l = 1; l < 8; l++) begin
                bit same;
                same = 1'b1;
                for (int t = 0; t < l; t++)
                    if (p[7-t] != p[l-1-t]) same = 1'b0;
                if (same) border = l;
            end
            do_reset(1);
            hits = 0;
            for (int i = 7; i >= 0; i--) begin
                send(p[i]);
                if (match_w[s]) hits++;
            end
            for (int i = 7 - border; i >= 0; i--) begin
                send(p[i]);
                if (match_w[s]) hits++;
            end
            check(hits == 2, "R4 overlap", $sformatf("sel %0d border %0d", s, border), hits, 2);
        end

        // R8: seven leading bits, reset, final bit: no flag.
        p = tb_pat(0);
        do_reset(1);
        for (int i = 7; i >= 1; i--) send(p[i]);
        do_reset(1);
        send(p[0]);
        check(match_w[0] === 1'b0, "R8 partial discard", "sel 0", int'(match_w[0]), 0);

        // R5: random stream.
        do_reset(1);
        repeat (3000) send(1'($urandom % 2));

        // R4, R5: dense stream built from pattern fragments.
        repeat (400) begin
            int s;
            int cut;
            s = int'($urandom % 5);
            cut = int'($urandom % 8);
            p = tb_pat(s);
            for (int i = 7; i >= cut; i--) send(p[i]);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule